// File: doc/BRIEF.md
# Bus Master Access Sequencer with Write-Back Suspend

This block runs single master accesses on a shared local bus for a DMA-style engine. Requests come in one at a time over a valid/ready handshake, each carrying an address, a direction, write data and a flag that allows burst-ready termination. The sequencer drives an address phase with a one-cycle address strobe. It then holds the cycle-type selects and data in a wait phase until the access is terminated. Read data is returned with a single-cycle response pulse.

While the block owns the bus, a write-back request from the system forces it off the bus. All master outputs are released in the next cycle and the interrupted access is parked. Once the write-back input drops, the parked access is re-driven in full before any new request is taken. Losing ownership also releases the bus. In that case the held access stays pending and is restarted when ownership returns. A completion counter lets the surrounding logic see that each access finished exactly once.

Top module: `lbm_seq`

## Requirements
- R1: After reset all bus outputs are released (bus_oe_o, ads_o, mio_o, wr_o low, address and write data zero), rsp_valid_o is low and done_cnt_o is zero.
- R2: req_ready_o is high only when no access is held, the block is not driving the bus, own_i is high and wback_i is low. A request transfers on a cycle where req_valid_i and req_ready_o are both high.
- R3: In the cycle after a request is taken, the block drives the bus: bus_oe_o=1, ads_o=1 for exactly that cycle, mio_o=1, wr_o equal to the request's write bit (1 = write), bus_addr_o equal to the request address, and bus_wdata_o equal to the write data for writes.
- R4: Whenever bus_oe_o is low, mio_o, wr_o and ads_o are low and bus_addr_o and bus_wdata_o are zero. bus_wdata_o is also zero during read accesses.
- R5: After the address cycle the access waits. It ends at the first edge where rdy_rtn_i is sampled high. burst_rdy_i also ends it, but only for requests whose burst flag was set; otherwise burst_rdy_i has no effect.
- R6: A read that ends at an edge raises rsp_valid_o for exactly the next cycle, with rsp_rdata_o equal to bus_rdata_i sampled at that edge. A write produces no response.
- R7: If wback_i is sampled high while the block drives the bus, all master outputs are released in the next cycle and stay released while wback_i remains high.
- R8: When wback_i falls after a suspend, the block waits one released cycle and then re-drives the same access (same address, direction and data) with a fresh address strobe. No new request is accepted until that access ends.
- R9: If own_i is sampled low, the block releases the bus in the next cycle and keeps the held access. When own_i returns with wback_i low, the held access restarts from its address cycle.
- R10: done_cnt_o increases by exactly one, with wrap-around, in the cycle after each access ends, and at no other time.
- R11: If wback_i and a terminating ready are sampled at the same edge, the write-back wins: the access is suspended, not counted and replayed later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_i | input | 1 | Block is the current bus owner |
| wback_i | input | 1 | Write-back request; forces the block off the bus |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be taken |
| req_addr_i | input | ADDR_W | Request address |
| req_write_i | input | 1 | Request direction, 1 = write |
| req_wdata_i | input | DATA_W | Request write data |
| req_burst_i | input | 1 | Request may end on burst-ready |
| rdy_rtn_i | input | 1 | Ready-return termination, active high |
| burst_rdy_i | input | 1 | Burst-ready termination, active high |
| bus_rdata_i | input | DATA_W | Read data from the bus |
| bus_oe_o | output | 1 | Master outputs driven (0 = released) |
| ads_o | output | 1 | Address strobe |
| mio_o | output | 1 | Memory/IO select, high on master cycles |
| wr_o | output | 1 | Write/read select |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| rsp_valid_o | output | 1 | Read response pulse |
| rsp_rdata_o | output | DATA_W | Read response data |
| done_cnt_o | output | CNT_W | Completed access counter |

## Verification
Directed sequences cover these cases:
- A write that sees burst-ready without the burst flag, which shows that the flag gates burst-ready termination.
- A burst read that ends on burst-ready, which shows the response path.
- A write-back arriving in the wait phase while a new request is already offered, which shows that the replay goes first.
- A write-back coinciding with ready-return, which shows the priority rule.
- An ownership drop in the address phase, which shows that the held access is kept and restarted.

A long pseudo-random run then mixes valid, direction, burst flag, ownership, write-back and both ready inputs. Each cycle is compared against a behavioural model. A lost, duplicated or reordered access shows up in the counter or in the address order.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_WAIT = 3'd2,
    ST_SUSP = 3'd3,
    ST_RPLY = 3'd4
  } lbm_st_e;

  function automatic logic st_drives(lbm_st_e st);
    return (st == ST_ADDR) || (st == ST_WAIT);
  endfunction
endpackage

// File: rtl/lbm_hold.sv
module lbm_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              burst_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              burst_o
);
  // one-entry replay register: kept until the access terminates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= 1'b0;
      addr_o  <= '0;
      write_o <= 1'b0;
      wdata_o <= '0;
      burst_o <= 1'b0;
    end else if (load_i) begin
      pend_o  <= 1'b1;
      addr_o  <= addr_i;
      write_o <= write_i;
      wdata_o <= wdata_i;
      burst_o <= burst_i;
    end else if (clr_i) begin
      pend_o  <= 1'b0;
    end
  end

  // R8
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !pend_o);

  // R8
  held_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !load_i && $past(pend_o)) |-> ($stable(addr_o) && $stable(write_o) && $stable(wdata_o)));
endmodule

// File: rtl/lbm_fsm.sv
module lbm_fsm
  import lbm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic own_i,
  input  logic wback_i,
  input  logic req_valid_i,
  input  logic pend_i,
  input  logic burst_i,
  input  logic rdy_rtn_i,
  input  logic burst_rdy_i,
  output logic req_ready_o,
  output logic load_o,
  output logic done_o,
  output logic drive_o,
  output logic ads_o
);
  lbm_st_e st_q, st_d;
  logic    term;

  assign term        = rdy_rtn_i || (burst_i && burst_rdy_i);
  assign req_ready_o = (st_q == ST_IDLE) && own_i && !wback_i && !pend_i;
  assign load_o      = req_ready_o && req_valid_i;
  // write-back takes priority over a same-edge termination
  assign done_o      = (st_q == ST_WAIT) && own_i && !wback_i && term;
  assign drive_o     = st_drives(st_q);
  assign ads_o       = (st_q == ST_ADDR);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (own_i && !wback_i && (pend_i || req_valid_i)) st_d = ST_ADDR;
      end
      ST_ADDR: begin
        if (!own_i)       st_d = ST_IDLE;
        else if (wback_i) st_d = ST_SUSP;
        else              st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!own_i)       st_d = ST_IDLE;
        else if (wback_i) st_d = ST_SUSP;
        else if (term)    st_d = ST_IDLE;
      end
      ST_SUSP: begin
        if (!own_i)       st_d = ST_IDLE;
        else if (!wback_i) st_d = ST_RPLY;
      end
      ST_RPLY: begin
        if (!own_i)       st_d = ST_IDLE;
        else if (wback_i) st_d = ST_SUSP;
        else              st_d = ST_ADDR;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // R2
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !drive_o);

  // R3
  accept_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> ads_o);

  // R7
  wback_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && wback_i) |=> !drive_o);

  // R8
  replay_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_RPLY) && own_i && !wback_i) |=> ads_o);

  // R9
  own_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !own_i |=> !drive_o);

  // R11
  wback_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && wback_i && rdy_rtn_i) |=> (!done_o && pend_i));
endmodule

// File: rtl/lbm_cnt.sv
module lbm_cnt #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= done_i && !write_i;
      if (done_i) cnt_o <= cnt_o + 1'b1;
      if (done_i && !write_i) rsp_rdata_o <= rdata_i;
    end
  end

  // R10
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_o) |-> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  // R6
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: rtl/lbm_seq.sv
module lbm_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              own_i,
  input  logic              wback_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_burst_i,
  input  logic              rdy_rtn_i,
  input  logic              burst_rdy_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_oe_o,
  output logic              ads_o,
  output logic              mio_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [CNT_W-1:0]  done_cnt_o
);
  logic              load, done, drive, pend;
  logic [ADDR_W-1:0] h_addr;
  logic              h_write, h_burst;
  logic [DATA_W-1:0] h_wdata;

  lbm_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .clr_i   (done),
    .addr_i  (req_addr_i),
    .write_i (req_write_i),
    .wdata_i (req_wdata_i),
    .burst_i (req_burst_i),
    .pend_o  (pend),
    .addr_o  (h_addr),
    .write_o (h_write),
    .wdata_o (h_wdata),
    .burst_o (h_burst)
  );

  lbm_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .own_i       (own_i),
    .wback_i     (wback_i),
    .req_valid_i (req_valid_i),
    .pend_i      (pend),
    .burst_i     (h_burst),
    .rdy_rtn_i   (rdy_rtn_i),
    .burst_rdy_i (burst_rdy_i),
    .req_ready_o (req_ready_o),
    .load_o      (load),
    .done_o      (done),
    .drive_o     (drive),
    .ads_o       (ads_o)
  );

  lbm_cnt #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .write_i     (h_write),
    .rdata_i     (bus_rdata_i),
    .cnt_o       (done_cnt_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  // released outputs read as zero; bus_oe_o is the float control
  assign bus_oe_o    = drive;
  assign mio_o       = drive;
  assign wr_o        = drive && h_write;
  assign bus_addr_o  = drive ? h_addr : '0;
  assign bus_wdata_o = (drive && h_write) ? h_wdata : '0;

  // R4
  release_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_oe_o) |-> (!ads_o && !wr_o && !mio_o && (bus_addr_o == '0)));
endmodule

// File: tb/lbm_seq_test.sv
`timescale 1ns/1ps
module lbm_seq_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam logic [31:0] RD_KEY = 32'hC3A5_0F1E;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          d_own = 1'b0, d_wb = 1'b0, d_valid = 1'b0, d_write = 1'b0, d_burst = 1'b0;
  logic          d_rdy = 1'b0, d_brdy = 1'b0;
  logic [AW-1:0] d_addr = '0;
  logic [DW-1:0] d_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          req_ready, bus_oe, ads, mio, wr, rsp_valid;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, rsp_rdata;
  logic [CW-1:0] done_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int wd = 0;

  always #4 clk = ~clk;

  assign bus_rdata = bus_addr ^ RD_KEY;

  lbm_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .own_i(d_own), .wback_i(d_wb),
    .req_valid_i(d_valid), .req_ready_o(req_ready), .req_addr_i(d_addr),
    .req_write_i(d_write), .req_wdata_i(d_wdata), .req_burst_i(d_burst),
    .rdy_rtn_i(d_rdy), .burst_rdy_i(d_brdy), .bus_rdata_i(bus_rdata),
    .bus_oe_o(bus_oe), .ads_o(ads), .mio_o(mio), .wr_o(wr),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .done_cnt_o(done_cnt)
  );

  // behavioural model: phase 0 idle, 1 strobe, 2 waiting, 3 parked, 4 restart gap
  int            m_ph;
  bit            m_held, m_wr, m_bu, m_rv;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wd, m_rd;
  int            m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_held = 0; m_wr = 0; m_bu = 0; m_rv = 0;
      m_addr = '0; m_wd = '0; m_rd = '0; m_cnt = 0;
    end else begin
      m_rv = 0;
      if (m_ph == 0) begin
        if (d_own && !d_wb) begin
          if (m_held) m_ph = 1;
          else if (d_valid) begin
            m_held = 1; m_addr = d_addr; m_wr = d_write; m_wd = d_wdata; m_bu = d_burst;
            m_ph = 1;
          end
        end
      end else if (!d_own) m_ph = 0;
      else if (m_ph == 1) m_ph = d_wb ? 3 : 2;
      else if (m_ph == 2) begin
        if (d_wb) m_ph = 3;
        else if (d_rdy || (m_bu && d_brdy)) begin
          m_ph = 0; m_held = 0; m_cnt = (m_cnt + 1) % (1 << CW);
          if (!m_wr) begin m_rv = 1; m_rd = m_addr ^ RD_KEY; end
        end
      end else if (m_ph == 3) begin
        if (!d_wb) m_ph = 4;
      end else m_ph = d_wb ? 3 : 1;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit drv;
    drv = (m_ph == 1) || (m_ph == 2);
    chk("R2", "req_ready", 32'(req_ready), 32'(m_ph == 0 && d_own && !d_wb && !m_held));
    chk("R4", "bus_oe", 32'(bus_oe), 32'(drv));
    chk("R3", "ads", 32'(ads), 32'(m_ph == 1));
    chk("R3", "mio", 32'(mio), 32'(drv));
    chk("R3", "wr", 32'(wr), 32'(drv && m_wr));
    chk("R3", "bus_addr", bus_addr, drv ? m_addr : 32'h0);
    chk("R4", "bus_wdata", bus_wdata, (drv && m_wr) ? m_wd : 32'h0);
    chk("R6", "rsp_valid", 32'(rsp_valid), 32'(m_rv));
    chk("R6", "rsp_rdata", rsp_rdata, m_rd);
    chk("R10", "done_cnt", 32'(done_cnt), 32'(m_cnt));
  endtask

  task automatic cyc(input logic v, input logic [31:0] a, input logic w, input logic [31:0] d,
                     input logic b, input logic o, input logic wb, input logic r, input logic br);
    @(negedge clk);
    d_valid = v; d_addr = a; d_write = w; d_wdata = d; d_burst = b;
    d_own = o; d_wb = wb; d_rdy = r; d_brdy = br;
    #1 compare_all();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R1", "oe after reset", 32'(bus_oe), 0);
    chk("R1", "cnt after reset", 32'(done_cnt), 0);
    chk("R1", "rsp after reset", 32'(rsp_valid), 0);
    // write with burst-ready but no burst flag
    cyc(1, 32'h100, 1, 32'hAAAA, 0, 1, 0, 0, 0);
    chk("R2", "ready idle", 32'(req_ready), 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R3", "strobe", 32'(ads), 1);
    chk("R3", "addr", bus_addr, 32'h100);
    chk("R3", "wdata", bus_wdata, 32'hAAAA);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R5", "burst-ready ignored w/o flag", 32'(bus_oe), 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R10", "count one", 32'(done_cnt), 1);
    // burst read ended on burst-ready
    cyc(1, 32'h200, 0, 32'h0, 1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R6", "read pulse", 32'(rsp_valid), 1);
    chk("R6", "read data", rsp_rdata, 32'h200 ^ RD_KEY);
    chk("R5", "burst end counted", 32'(done_cnt), 2);
    // write-back in wait phase, new request already offered
    cyc(1, 32'h300, 1, 32'h3333, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0);
    cyc(1, 32'h400, 1, 32'h4444, 0, 1, 1, 0, 0);
    chk("R7", "released under wback", 32'(bus_oe), 0);
    cyc(1, 32'h400, 1, 32'h4444, 0, 1, 0, 0, 0);
    cyc(1, 32'h400, 1, 32'h4444, 0, 1, 0, 0, 0);
    chk("R8", "gap cycle released", 32'(bus_oe), 0);
    chk("R8", "no new take in gap", 32'(req_ready), 0);
    cyc(1, 32'h400, 1, 32'h4444, 0, 1, 0, 0, 0);
    chk("R8", "replay strobe", 32'(ads), 1);
    chk("R8", "replay addr", bus_addr, 32'h300);
    chk("R8", "replay data", bus_wdata, 32'h3333);
    cyc(1, 32'h400, 1, 32'h4444, 0, 1, 0, 1, 0);
    cyc(1, 32'h400, 1, 32'h4444, 0, 1, 0, 0, 0);
    chk("R10", "replayed once", 32'(done_cnt), 3);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R8", "next access after replay", bus_addr, 32'h400);
    // write-back and ready at the same edge
    cyc(0, 0, 0, 0, 0, 1, 1, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R11", "not counted", 32'(done_cnt), 3);
    chk("R11", "released", 32'(bus_oe), 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R11", "replayed addr", bus_addr, 32'h400);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R11", "counted after replay", 32'(done_cnt), 4);
    // ownership loss in address phase
    cyc(1, 32'h500, 0, 32'h0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", "released on loss", 32'(bus_oe), 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9", "held blocks ready", 32'(req_ready), 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9", "restart strobe", 32'(ads), 1);
    chk("R9", "restart addr", bus_addr, 32'h500);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9", "restart counted", 32'(done_cnt), 5);
    // mixed pseudo-random traffic
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 3) != 0, $urandom, $urandom % 2, $urandom, $urandom % 2,
          ($urandom % 12) != 0, ($urandom % 7) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0);
    end
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1, 0, 1, 1);
    finish_run();
  end
endmodule